// File: doc/BRIEF.md
# MDIO Management Frame Receiver

This block is the management slave of an Ethernet PHY. It samples the MDIO line on every rising edge of MDC and finds the start of each frame. It then decodes the opcode, the PHY address and the register address, skips the turnaround, and moves 16 data bits to or from a small register file. Reads drive MDIO back to the station manager. Frames that carry a different PHY address are parsed but have no effect.

The register file has three registers:
- A basic status register at address 01h.
- A vendor configuration register at address 18h.
- A compatibility register at address 1Ch.

The configuration register holds five control bits: preamble required, fast timers, clock-output disable, link-check enable and transmit off. These bits appear directly as outputs. The preamble-required bit sets the rule for what counts as a valid frame, and software can change it at any time. The compatibility bit freezes two of the configuration bits. Two strap pins set the reset values of the clock-output disable bit and the link-check enable bit.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: A frame is: start bits 0,1; opcode 0,1 (write) or 1,0 (read); PHY address 5 bits MSB first; register address 5 bits MSB first; two turnaround bits; 16 data bits MSB first. A write to a matching PHY stores the data, and a later read of the same register returns it. Unmapped addresses read as 0 and ignore writes.
- R2: On a read with a matching address, `mdio_oe` stays low for the first turnaround bit period. During the second turnaround period the block drives 0. In the next 16 bit periods it drives the data MSB first, and it releases `mdio_oe` in the bit period after the last data bit.
- R3: With the preamble-required bit set (config bit 0), a frame takes effect only if at least 32 consecutive ones come before its start bits. A frame with 31 ones is ignored.
- R4: With the preamble-required bit clear, frames take effect with a full preamble and with no preamble at all.
- R5: Status register bit 6 reads as the inverse of the preamble-required bit. Every other status bit reads 0.
- R6: While bit 0 of register 1Ch is set, writes leave config bits 0 (preamble required) and 1 (fast timers) unchanged. Config bits 2 to 4 still take the written values.
- R7: After reset, config bits 0, 1 and 4 are 0. Config bit 2 (clock-output disable) is 1 when `tst_strap` is low and 0 when it is high. Config bit 3 (link-check enable) is the inverse of `rptr_strap`. Register 1Ch is 0.
- R8: While config bit 3 is clear, `link_ok` and `speed100` are 1 and `link_led_n` is 0, whatever `link_in` and `speed_in` are. While it is set, `link_ok` follows `link_in`, `speed100` follows `speed_in`, and `link_led_n` is the inverse of `link_ok`.
- R9: A frame whose PHY address differs from `phy_addr` writes nothing and never raises `mdio_oe`.
- R10: A frame whose start bits are not 0,1, or whose opcode is 00 or 11, has no effect. The parser then returns to preamble search, and a later valid frame works.
- R11: `fast_timers`, `clk_out_dis` and `tx_off` show config bits 1, 2 and 4 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| phy_addr | input | 5 | Strapped PHY address |
| tst_strap | input | 1 | Test strap; low makes the clock-output disable bit reset to 1 |
| rptr_strap | input | 1 | Repeater strap; its inverse is the reset value of link-check enable |
| mdio_in | input | 1 | Sampled MDIO line |
| mdio_out | output | 1 | MDIO value driven during reads |
| mdio_oe | output | 1 | MDIO output enable |
| link_in | input | 1 | Link status from the link monitor |
| speed_in | input | 1 | Speed indication from the link monitor (1 = 100 Mb/s) |
| link_ok | output | 1 | Link status after forcing |
| speed100 | output | 1 | Speed after forcing |
| link_led_n | output | 1 | Link LED, active low |
| fast_timers | output | 1 | Fast-timer test control |
| clk_out_dis | output | 1 | Clock-output disable control |
| tx_off | output | 1 | Transmit disable control |

## Verification
A bit counts as taken when the `mdc` edge that samples it has passed. The bench therefore drives `mdio_in` on falling edges and also samples on falling edges, half a period away from where the design acts.

The control outputs change at the edge that samples the last data bit of a write, so they are checked one falling edge after that. During a read, the bench checks `mdio_oe` and `mdio_out` at the falling edge inside each bit period from the first turnaround bit onward. It expects:
- released during the first turnaround period;
- 0 during the second turnaround period;
- one data bit per period after that;
- released again in the period after the last data bit.

Frames that must be ignored are read back afterwards with a valid frame. The bench also records whether `mdio_oe` rose at any point during them.

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave #(
  parameter int AW = 5,
  parameter int DW = 16,
  parameter int PRE_MIN = 32,
  parameter logic [AW-1:0] STAT_ADDR = 5'h01,
  parameter logic [AW-1:0] CFG_ADDR = 5'h18,
  parameter logic [AW-1:0] COMPAT_ADDR = 5'h1C
) (
  input  logic          mdc,
  input  logic          rst_n,
  input  logic [AW-1:0] phy_addr,
  input  logic          tst_strap,
  input  logic          rptr_strap,
  input  logic          mdio_in,
  output logic          mdio_out,
  output logic          mdio_oe,
  input  logic          link_in,
  input  logic          speed_in,
  output logic          link_ok,
  output logic          speed100,
  output logic          link_led_n,
  output logic          fast_timers,
  output logic          clk_out_dis,
  output logic          tx_off
);
  localparam int HW = 2 + 2 * AW;
  localparam int CW = $clog2(PRE_MIN + 1);
  localparam int BW = $clog2((DW > HW) ? DW : HW);

  typedef enum logic [2:0] {S_IDLE, S_START, S_HDR, S_TA, S_DATA} st_t;

  st_t state;
  logic [CW-1:0] ones;
  logic [HW-2:0] hdr;
  logic [BW-1:0] bcnt;
  logic [DW-2:0] sh;
  logic rd_op, hit;
  logic pre_req, fast, clkdis, link_en, txoff, compat;
  logic [DW-1:0] rdata;

  wire [HW-1:0] hdr_nx = {hdr, mdio_in};
  wire pre_ok = !pre_req || (ones >= CW'(PRE_MIN));
  wire [4:0] wd = {sh[3:0], mdio_in};
  wire [1:0] op_nx = hdr_nx[1:0];

  always_comb begin
    rdata = '0;
    case (hdr[AW-1:0])
      STAT_ADDR:   rdata[6] = ~pre_req;
      CFG_ADDR:    rdata[4:0] = {txoff, link_en, clkdis, fast, pre_req};
      COMPAT_ADDR: rdata[0] = compat;
      default:     rdata = '0;
    endcase
  end

  always_ff @(posedge mdc) begin
    if (!rst_n) begin
      state <= S_IDLE;
      ones <= '0;
      hdr <= '0;
      bcnt <= '0;
      sh <= '0;
      rd_op <= 1'b0;
      hit <= 1'b0;
      mdio_oe <= 1'b0;
      mdio_out <= 1'b0;
      pre_req <= 1'b0;
      fast <= 1'b0;
      txoff <= 1'b0;
      clkdis <= ~tst_strap;
      link_en <= ~rptr_strap;
      compat <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (mdio_in) begin
            if (ones != CW'(PRE_MIN)) ones <= ones + 1'b1;
          end else begin
            ones <= '0;
            if (pre_ok) state <= S_START;
          end
        end
        S_START: begin
          bcnt <= '0;
          state <= mdio_in ? S_HDR : S_IDLE;
        end
        S_HDR: begin
          hdr <= hdr_nx[HW-2:0];
          bcnt <= bcnt + 1'b1;
          if (bcnt == BW'(1) && !(op_nx == 2'b10 || op_nx == 2'b01)) begin
            state <= S_IDLE;
          end else if (bcnt == BW'(HW-1)) begin
            state <= S_TA;
            bcnt <= '0;
            rd_op <= (hdr_nx[HW-1:HW-2] == 2'b10);
            hit <= (hdr_nx[2*AW-1:AW] == phy_addr);
          end
        end
        S_TA: begin
          bcnt <= bcnt + 1'b1;
          if (bcnt == '0) begin
            if (rd_op && hit) begin
              mdio_oe <= 1'b1;
              mdio_out <= 1'b0;
            end
          end else begin
            state <= S_DATA;
            bcnt <= '0;
            if (rd_op && hit) begin
              sh <= rdata[DW-2:0];
              mdio_out <= rdata[DW-1];
            end
          end
        end
        S_DATA: begin
          bcnt <= bcnt + 1'b1;
          if (rd_op) begin
            mdio_out <= sh[DW-2];
            sh <= {sh[DW-3:0], 1'b0};
          end else begin
            sh <= {sh[DW-3:0], mdio_in};
          end
          if (bcnt == BW'(DW-1)) begin
            state <= S_IDLE;
            mdio_oe <= 1'b0;
            ones <= '0;
            if (!rd_op && hit) begin
              if (hdr[AW-1:0] == CFG_ADDR) begin
                if (!compat) begin
                  pre_req <= wd[0];
                  fast <= wd[1];
                end
                clkdis <= wd[2];
                link_en <= wd[3];
                txoff <= wd[4];
              end else if (hdr[AW-1:0] == COMPAT_ADDR) begin
                compat <= wd[0];
              end
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign link_ok = link_en ? link_in : 1'b1;
  assign speed100 = link_en ? speed_in : 1'b1;
  assign link_led_n = ~link_ok;
  assign fast_timers = fast;
  assign clk_out_dis = clkdis;
  assign tx_off = txoff;
endmodule

// File: rtl/mdio_mgmt_slave_chk.sv
module mdio_mgmt_slave_chk (
  input logic       mdc,
  input logic       rst_n,
  input logic       mdio_oe,
  input logic       mdio_out,
  input logic [2:0] st,
  input logic       compat,
  input logic       pre_req,
  input logic       fast,
  input logic       link_en,
  input logic       link_ok,
  input logic       speed100,
  input logic       link_led_n
);
  logic [4:0] oe_len;

  always_ff @(posedge mdc) begin
    if (!rst_n) oe_len <= '0;
    else if (mdio_oe) oe_len <= oe_len + 1'b1;
    else oe_len <= '0;
  end

  p_ta_zero_r2: assert property (@(posedge mdc) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_out);

  p_drive_len_r2: assert property (@(posedge mdc) disable iff (!rst_n)
    $fell(mdio_oe) |-> oe_len == 5'd17);

  p_oe_phase_r2: assert property (@(posedge mdc) disable iff (!rst_n)
    mdio_oe |-> (st == 3'd3 || st == 3'd4));

  p_lock_r6: assert property (@(posedge mdc) disable iff (!rst_n)
    compat |=> $stable(pre_req) && $stable(fast));

  p_link_force_r8: assert property (@(posedge mdc) disable iff (!rst_n)
    !link_en |-> link_ok && speed100 && !link_led_n);
endmodule

bind mdio_mgmt_slave mdio_mgmt_slave_chk u_chk (
  .mdc(mdc), .rst_n(rst_n), .mdio_oe(mdio_oe), .mdio_out(mdio_out),
  .st(state), .compat(compat), .pre_req(pre_req), .fast(fast),
  .link_en(link_en), .link_ok(link_ok), .speed100(speed100),
  .link_led_n(link_led_n)
);

// File: tb/tb_mdio_mgmt_slave.sv
`timescale 1ns/1ps
module tb_mdio_mgmt_slave;
  localparam logic [4:0] PHY = 5'h03;
  localparam logic [4:0] OTHER = 5'h0A;

  logic mdc = 1'b0, rst_n = 1'b0, tst_strap = 1'b0, rptr_strap = 1'b0;
  logic mdio_in = 1'b1, link_in = 1'b0, speed_in = 1'b0;
  logic mdio_out, mdio_oe, link_ok, speed100, link_led_n, fast_timers, clk_out_dis, tx_off;
  int n_run = 0, n_fail = 0;

  always #2 mdc = ~mdc;

  mdio_mgmt_slave dut (
    .mdc(mdc), .rst_n(rst_n), .phy_addr(PHY), .tst_strap(tst_strap),
    .rptr_strap(rptr_strap), .mdio_in(mdio_in), .mdio_out(mdio_out),
    .mdio_oe(mdio_oe), .link_in(link_in), .speed_in(speed_in),
    .link_ok(link_ok), .speed100(speed100), .link_led_n(link_led_n),
    .fast_timers(fast_timers), .clk_out_dis(clk_out_dis), .tx_off(tx_off)
  );

  // {is_write, reg, write data, expected readback}
  localparam logic [37:0] VEC [8] = '{
    {1'b0, 5'h18, 16'h0000, 16'h000C},
    {1'b0, 5'h01, 16'h0000, 16'h0040},
    {1'b1, 5'h18, 16'hFFE2, 16'h0002},
    {1'b1, 5'h18, 16'h0015, 16'h0015},
    {1'b0, 5'h01, 16'h0000, 16'h0000},
    {1'b1, 5'h18, 16'h000A, 16'h000A},
    {1'b0, 5'h01, 16'h0000, 16'h0040},
    {1'b1, 5'h05, 16'hBEEF, 16'h0000}
  };

  task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bit_out(input logic b);
    @(negedge mdc);
    mdio_in = b;
    @(posedge mdc);
  endtask

  task automatic frame(input int npre, input logic [1:0] st, input logic [1:0] op,
                       input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] d);
    repeat (npre) bit_out(1'b1);
    bit_out(st[1]); bit_out(st[0]);
    bit_out(op[1]); bit_out(op[0]);
    for (int i = 4; i >= 0; i--) bit_out(pa[i]);
    for (int i = 4; i >= 0; i--) bit_out(ra[i]);
    bit_out(1'b1); bit_out(1'b0);
    for (int i = 15; i >= 0; i--) bit_out(d[i]);
    bit_out(1'b1); bit_out(1'b1);
  endtask

  task automatic wr(input int npre, input logic [4:0] ra, input logic [15:0] d);
    frame(npre, 2'b01, 2'b01, PHY, ra, d);
  endtask

  task automatic rd(input int npre, input logic [4:0] pa, input logic [4:0] ra,
                    output logic [15:0] d, output logic proto, output logic drove);
    proto = 1'b1; drove = 1'b0; d = '0;
    repeat (npre) bit_out(1'b1);
    bit_out(1'b0); bit_out(1'b1); bit_out(1'b1); bit_out(1'b0);
    for (int i = 4; i >= 0; i--) bit_out(pa[i]);
    for (int i = 4; i >= 0; i--) bit_out(ra[i]);
    @(negedge mdc); mdio_in = 1'b1;
    if (mdio_oe) begin proto = 1'b0; drove = 1'b1; end
    @(posedge mdc);
    @(negedge mdc);
    if (!(mdio_oe && !mdio_out)) proto = 1'b0;
    drove |= mdio_oe;
    @(posedge mdc);
    for (int i = 0; i < 16; i++) begin
      @(negedge mdc);
      drove |= mdio_oe;
      if (!mdio_oe) proto = 1'b0;
      d = {d[14:0], mdio_out};
      @(posedge mdc);
    end
    @(negedge mdc);
    if (mdio_oe) begin proto = 1'b0; drove = 1'b1; end
    @(posedge mdc);
    bit_out(1'b1);
  endtask

  task automatic rd_expect(input logic [4:0] ra, input logic [15:0] exp, input string tag);
    logic [15:0] d; logic p, dr;
    rd(32, PHY, ra, d, p, dr);
    chk(p, {tag, " read timing"}, {15'd0, p}, 16'd1);
    chk(d == exp, tag, d, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge mdc);
    @(negedge mdc);
    rst_n = 1'b1;
    @(negedge mdc);
  endtask

  initial begin
    repeat (150000) @(posedge mdc);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] d; logic p, dr;
    do_reset();
    // R7 reset state, straps low
    chk(clk_out_dis == 1'b1, "R7 clk_out_dis", {15'd0, clk_out_dis}, 16'd1);
    chk(!fast_timers && !tx_off, "R7 fast/tx", {14'd0, fast_timers, tx_off}, 16'd0);
    chk(link_ok == 1'b0, "R8 link follows input", {15'd0, link_ok}, 16'd0);

    // table walk: R1, R2, R5, R7
    for (int i = 0; i < 8; i++) begin
      logic [37:0] v;
      v = VEC[i];
      if (v[37]) wr(32, v[36:32], v[31:16]);
      rd(32, PHY, v[36:32], d, p, dr);
      chk(p, "R2 read turnaround/data timing", {15'd0, p}, 16'd1);
      chk(d == v[15:0], "R1 table readback", d, v[15:0]);
    end

    // R11 outputs show config bits
    wr(32, 5'h18, 16'h001C);
    chk({tx_off, clk_out_dis, fast_timers} == 3'b110, "R11 outputs",
        {13'd0, tx_off, clk_out_dis, fast_timers}, 16'h6);
    wr(32, 5'h18, 16'h0002);
    chk({tx_off, clk_out_dis, fast_timers} == 3'b001, "R11 outputs b",
        {13'd0, tx_off, clk_out_dis, fast_timers}, 16'h1);

    // R8 link forcing
    chk(link_ok && speed100 && !link_led_n, "R8 forced", {13'd0, link_ok, speed100, link_led_n}, 16'h6);
    wr(32, 5'h18, 16'h0008);
    chk(!link_ok && !speed100 && link_led_n, "R8 follow", {13'd0, link_ok, speed100, link_led_n}, 16'h1);
    link_in = 1'b1; speed_in = 1'b1;
    @(negedge mdc);
    chk(link_ok && speed100 && !link_led_n, "R8 follow high", {13'd0, link_ok, speed100, link_led_n}, 16'h6);

    // R4 preamble optional
    rd(0, PHY, 5'h18, d, p, dr);
    chk(p && d == 16'h0008, "R4 no-preamble read", d, 16'h0008);
    wr(0, 5'h18, 16'h0018);
    rd_expect(5'h18, 16'h0018, "R4 no-preamble write");
    wr(32, 5'h18, 16'h0008);

    // R3 preamble required
    wr(32, 5'h18, 16'h0009);
    bit_out(1'b0);
    rd(31, PHY, 5'h18, d, p, dr);
    chk(!dr, "R3 31-one read ignored", {15'd0, dr}, 16'd0);
    rd_expect(5'h18, 16'h0009, "R3 32-one read");
    wr(0, 5'h18, 16'h0008);
    rd_expect(5'h18, 16'h0009, "R3 no-preamble write ignored");

    // R10 bad opcode and bad start
    frame(32, 2'b01, 2'b11, PHY, 5'h18, 16'h0000);
    rd_expect(5'h18, 16'h0009, "R10 bad opcode ignored");
    frame(32, 2'b00, 2'b01, PHY, 5'h18, 16'h0000);
    rd_expect(5'h18, 16'h0009, "R10 bad start ignored");

    // R6 compatibility lock
    wr(32, 5'h1C, 16'h0001);
    rd_expect(5'h1C, 16'h0001, "R6 compat set");
    wr(32, 5'h18, 16'h0002);
    rd_expect(5'h18, 16'h0001, "R6 locked bits kept");
    wr(32, 5'h1C, 16'h0000);
    wr(32, 5'h18, 16'h0008);
    rd_expect(5'h18, 16'h0008, "R6 unlocked write");

    // R9 PHY address mismatch
    frame(32, 2'b01, 2'b01, OTHER, 5'h18, 16'h001F);
    rd_expect(5'h18, 16'h0008, "R9 foreign write ignored");
    rd(32, OTHER, 5'h18, d, p, dr);
    chk(!dr, "R9 foreign read no drive", {15'd0, dr}, 16'd0);

    // R7 reset with straps high
    tst_strap = 1'b1; rptr_strap = 1'b1; link_in = 1'b0; speed_in = 1'b0;
    do_reset();
    chk(!clk_out_dis && !fast_timers && !tx_off, "R7 straps high outputs",
        {13'd0, clk_out_dis, fast_timers, tx_off}, 16'd0);
    chk(link_ok && speed100 && !link_led_n, "R7 link check off after reset",
        {13'd0, link_ok, speed100, link_led_n}, 16'h6);
    rd_expect(5'h18, 16'h0000, "R7 config reset");
    rd_expect(5'h01, 16'h0040, "R5 status after reset");
    rd_expect(5'h1C, 16'h0000, "R7 compat reset");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule